// File: doc/BRIEF.md
# Clause 22 MDIO Management Controller

This block is a memory-mapped MDIO master that reaches Clause 22 PHY registers over the two-wire management bus. A host writes one 32-bit command word that carries a PHY address, a register number, a read/write select and, for writes, 16 bits of data. The write starts a complete serial frame on MDC/MDIO. The same word reads back with a busy flag that stays set while the frame runs. When a read finishes, the returned value appears in the low half of that word, and a flag shows whether the PHY answered.

Each finished transaction also sets a sticky "access done" cause bit. That bit is ANDed with a mask bit to drive a level interrupt, so a host can sleep until completion or poll the busy flag. The MDC clock is the system clock divided by an even, parameterised ratio. With the default of 40 system cycles per half period, a 200 MHz system clock gives 2.5 MHz MDC. The MDIO input passes through a parameterised synchronizer before it is sampled.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the words at offsets 0x00, 0x7C and 0x80 read as zero, and mdc, mdio_oe and irq are low.
- R2: The command word is laid out as data in bits 15:0, PHY address in 20:16, register number in 25:21, operation in bit 26 (1 = read, 0 = write), read-valid in bit 27 and busy in bit 28. A write to offset 0x00 while idle sets busy and starts a frame. Bits 26:0 read back as written, except that read-valid is cleared.
- R3: Every frame is 64 MDC cycles long, in this order: 32 ones, start 01, opcode (10 read, 01 write), PHY address, register number, turnaround (10 on writes) and 16 data bits, each field MSB first. MDIO changes only on falling MDC.
- R4: MDC has a period of 2*DIV_HALF system clocks during a frame and stays low while idle.
- R5: On a read, the master releases MDIO (mdio_oe low) from the first turnaround bit to the end of the frame. It samples the 16 data bits on rising MDC, MSB first, and at completion stores them in bits 15:0 and sets read-valid (bit 27).
- R6: If the PHY does not drive the second turnaround bit low, read-valid stays clear after the read.
- R7: A write to offset 0x00 while busy is ignored: the fields read back unchanged and the running frame is not altered.
- R8: Completion sets cause bit 4 at offset 0x7C. Mask bit 4 at offset 0x80 is read/write. irq is high exactly when both bits are set.
- R9: Writing offset 0x7C with bit 4 at zero clears the cause bit. Writing it with bit 4 at one leaves the bit unchanged.
- R10: Busy clears no later than 128*DIV_HALF+8 system clocks after the command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |
| irq | output | 1 | Access-done interrupt |

## Verification
Several properties are checked on every cycle: MDC stays low whenever no frame runs, the master stays off MDIO during the turnaround and data bits of a read, read-valid is never set while busy, a command write during busy leaves the fields stable, and completion always sets the cause bit. Other properties can only be shown by the bench's scenarios. These are the exact bit order of captured frames, the MDC period, and the read data returned by a responding PHY. The bench also covers the invalid read when the PHY is absent, the latency bound, and the cause/mask interplay under writes of ones and zeros.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   // register byte offsets
   localparam logic [7:0] CMD_OFF   = 8'h00;
   localparam logic [7:0] CAUSE_OFF = 8'h7C;
   localparam logic [7:0] MASK_OFF  = 8'h80;
   // command word field positions
   localparam int DATA_W    = 16;
   localparam int ADR_W     = 5;
   localparam int PHY_LSB   = 16;
   localparam int REG_LSB   = 21;
   localparam int OP_BIT    = 26;
   localparam int DONE_BIT  = 4;
   // frame layout
   localparam int FRAME_LEN = 64;
   localparam int TA_IDX    = 46;
   localparam int DATA_IDX  = 48;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } mdio_op_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int DIV_HALF = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int CW = $clog2(DIV_HALF);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap      = en && (cnt == CW'(DIV_HALF - 1));
   assign rise_tick = wrap && !mdc;
   assign fall_tick = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc); // R4
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_HALF    = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_read,
   input  logic [ADR_W-1:0]  phy,
   input  logic [ADR_W-1:0]  regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mdio_i,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              active,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              ta_ok
);
   localparam int IW = $clog2(FRAME_LEN);

   if (DIV_HALF < 2) begin : g_bad_div
      $error("DIV_HALF must be at least 2");
   end
   if (SYNC_STAGES >= DIV_HALF) begin : g_bad_sync
      $error("SYNC_STAGES must be below DIV_HALF");
   end

   logic mdio_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else        ff <= (ff << 1) | SYNC_STAGES'(mdio_i);
      end
      assign mdio_s = ff[SYNC_STAGES-1];
   end

   logic rise_tick, fall_tick;
   mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .en(active),
      .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   logic [FRAME_LEN-1:0] sh;
   logic [IW-1:0]        idx;
   logic                 op_q;
   logic [FRAME_LEN-1:0] frame;

   assign frame = {32'hFFFF_FFFF, 2'b01, (op_read ? 2'b10 : 2'b01), phy, regad,
                   2'b10, (op_read ? 16'hFFFF : wdata)};
   assign mdio_o = sh[FRAME_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         idx     <= '0;
         sh      <= '0;
         op_q    <= 1'b0;
         mdio_oe <= 1'b0;
         done    <= 1'b0;
         rd_data <= '0;
         ta_ok   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active  <= 1'b1;
               idx     <= '0;
               op_q    <= op_read;
               sh      <= frame;
               mdio_oe <= 1'b1;
               ta_ok   <= 1'b0;
            end
         end else begin
            if (rise_tick && op_q) begin
               if (idx == IW'(TA_IDX + 1)) ta_ok <= !mdio_s;
               if (idx >= IW'(DATA_IDX))   rd_data <= {rd_data[DATA_W-2:0], mdio_s};
            end
            if (fall_tick) begin
               if (idx == IW'(FRAME_LEN - 1)) begin
                  active  <= 1'b0;
                  done    <= 1'b1;
                  mdio_oe <= 1'b0;
               end else begin
                  idx     <= idx + 1'b1;
                  sh      <= {sh[FRAME_LEN-2:0], 1'b0};
                  mdio_oe <= !(op_q && (idx >= IW'(TA_IDX - 1)));
               end
            end
         end
      end
   end

   AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && op_q && idx >= IW'(TA_IDX)) |-> !mdio_oe); // R5
   AST_DONE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(active)); // R10
endmodule

// File: rtl/mdio_done_irq.sv
module mdio_done_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic cause_we,
   input  logic mask_we,
   input  logic wr_bit,
   output logic cause,
   output logic mask,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause <= 1'b0;
         mask  <= 1'b0;
      end else begin
         if (done)          cause <= 1'b1;
         else if (cause_we) cause <= cause & wr_bit;
         if (mask_we)       mask  <= wr_bit;
      end
   end

   assign irq = cause & mask;

   AST_CAUSE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cause); // R8
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DIV_HALF    = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              irq
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x80");
   end

   logic [DATA_W-1:0] cmd_data;
   logic [ADR_W-1:0]  cmd_phy, cmd_reg;
   mdio_op_e          cmd_op;
   logic              cmd_rvalid, busy, start_q;
   logic              eng_active, eng_done, ta_ok;
   logic [DATA_W-1:0] rd_data;
   logic              cause, mask;
   logic              sel_cmd, sel_cause, sel_mask;
   logic              unused_bits;

   assign sel_cmd   = bus_we && (bus_addr == ADDR_W'(CMD_OFF));
   assign sel_cause = bus_we && (bus_addr == ADDR_W'(CAUSE_OFF));
   assign sel_mask  = bus_we && (bus_addr == ADDR_W'(MASK_OFF));
   assign unused_bits = ^{bus_wdata[31:27], eng_active};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_data   <= '0;
         cmd_phy    <= '0;
         cmd_reg    <= '0;
         cmd_op     <= OP_WRITE;
         cmd_rvalid <= 1'b0;
         busy       <= 1'b0;
         start_q    <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (sel_cmd && !busy) begin
            cmd_data   <= bus_wdata[DATA_W-1:0];
            cmd_phy    <= bus_wdata[PHY_LSB +: ADR_W];
            cmd_reg    <= bus_wdata[REG_LSB +: ADR_W];
            cmd_op     <= mdio_op_e'(bus_wdata[OP_BIT]);
            cmd_rvalid <= 1'b0;
            busy       <= 1'b1;
            start_q    <= 1'b1;
         end else if (eng_done) begin
            busy <= 1'b0;
            if (cmd_op == OP_READ) begin
               cmd_data   <= rd_data;
               cmd_rvalid <= ta_ok;
            end
         end
      end
   end

   mdio_frame_engine #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start_q), .op_read(cmd_op == OP_READ),
      .phy(cmd_phy), .regad(cmd_reg), .wdata(cmd_data), .mdio_i(mdio_i),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(eng_active),
      .done(eng_done), .rd_data(rd_data), .ta_ok(ta_ok)
   );

   mdio_done_irq u_irq (
      .clk(clk), .rst_n(rst_n), .done(eng_done), .cause_we(sel_cause),
      .mask_we(sel_mask), .wr_bit(bus_wdata[DONE_BIT]),
      .cause(cause), .mask(mask), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CMD_OFF))
         bus_rdata = {3'b000, busy, cmd_rvalid, cmd_op, cmd_reg, cmd_phy, cmd_data};
      else if (bus_addr == ADDR_W'(CAUSE_OFF))
         bus_rdata = 32'(cause) << DONE_BIT;
      else if (bus_addr == ADDR_W'(MASK_OFF))
         bus_rdata = 32'(mask) << DONE_BIT;
   end

   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rvalid |-> !busy); // R5
   AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel_cmd) |=> ($stable(cmd_phy) && $stable(cmd_reg) && $stable(cmd_op))); // R7
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
   localparam int DIVH     = 4;
   localparam logic [4:0] PHY_ADDR = 5'd3;
   localparam int BOUND    = 128*DIVH + 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i, irq;

   logic        phy_oe = 1'b0, phy_val = 1'b1;
   assign mdio_i = phy_oe ? phy_val : 1'b1;

   mdio_mgmt_ctrl #(.ADDR_W(8), .DIV_HALF(DIVH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
   );

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- PHY responder ----------------
   logic [15:0] phy_mem [32];
   logic [15:0] exp_mem [32];
   logic [63:0] frm = '0, last_frame = '0;
   int          bcnt = 0, frame_count = 0, oe_bad = 0;
   bit          cur_rd = 0, cur_match = 0;
   logic [4:0]  cur_reg = '0;
   time         t_prev = 0, last_period = 0;

   initial begin
      for (int i = 0; i < 32; i++) begin
         phy_mem[i] = 16'h5A00 ^ 16'(i * 16'h0321);
         exp_mem[i] = 16'h5A00 ^ 16'(i * 16'h0321);
      end
   end

   always @(posedge mdc) begin
      logic ln;
      ln = mdio_oe ? mdio_o : mdio_i;
      if (bcnt > 0) last_period = $time - t_prev;
      t_prev = $time;
      if (bcnt == 46) begin
         cur_rd    = ({frm[11], frm[10]} == 2'b10);
         cur_match = (frm[9:5] == PHY_ADDR);
         cur_reg   = frm[4:0];
      end
      if (bcnt >= 46 && cur_rd && mdio_oe) oe_bad++;
      frm = {frm[62:0], ln};
      bcnt++;
      if (bcnt == 64) begin
         last_frame = frm;
         frame_count++;
         bcnt = 0;
         if (frm[29:28] == 2'b01 && frm[27:23] == PHY_ADDR)
            phy_mem[frm[22:18]] = frm[15:0];
      end
   end

   always @(negedge mdc) begin
      if (bcnt == 47 && cur_rd && cur_match) begin
         phy_oe = 1'b1; phy_val = 1'b0;
      end else if (bcnt >= 48 && cur_rd && cur_match) begin
         phy_oe = 1'b1; phy_val = phy_mem[cur_reg][63 - bcnt];
      end else begin
         phy_oe = 1'b0; phy_val = 1'b1;
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
      if (!rd)            return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
      if (phy == PHY_ADDR) return {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 2'b10, exp_mem[rg]};
      return {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 2'b11, 16'hFFFF};
   endfunction

   task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input bit busy_poke);
      logic [31:0] w, r;
      int fc, cyc, oeb;
      w = {5'b0, rd, rg, phy, d};
      fc = frame_count; oeb = oe_bad;
      bus_wr(8'h00, w);
      bus_rd(8'h00, r);
      chk(r[28] == 1'b1 && r[27] == 1'b0, "R2 busy set on launch", r, w | 32'h1000_0000);
      chk(r[26:0] == w[26:0], "R2 field readback", r[26:0], w[26:0]);
      if (busy_poke) begin
         bus_wr(8'h00, ~w & 32'h07FF_FFFF);
         bus_rd(8'h00, r);
         chk(r[26:16] == w[26:16], "R7 write while busy ignored", r[26:16], w[26:16]);
      end
      cyc = 0;
      do begin
         bus_rd(8'h00, r);
         cyc++;
      end while (r[28] && cyc < 2*BOUND);
      chk(cyc <= BOUND, "R10 completion latency", cyc, BOUND);
      chk(frame_count == fc + 1 && last_frame == exp_frame(rd, phy, rg, d),
          "R3 frame content", last_frame, exp_frame(rd, phy, rg, d));
      chk(last_period == 2*DIVH*5, "R4 MDC period", last_period, 2*DIVH*5);
      chk(mdc == 1'b0, "R4 MDC low when idle", mdc, 0);
      if (rd) begin
         chk(oe_bad == oeb, "R5 MDIO released in read", oe_bad, oeb);
         if (phy == PHY_ADDR) begin
            chk(r[27] == 1'b1 && r[15:0] == exp_mem[rg], "R5 read data and valid",
                r[27:0], {1'b1, w[26:16], exp_mem[rg]});
         end else begin
            chk(r[27] == 1'b0, "R6 absent PHY leaves valid clear", r[27], 0);
         end
      end else begin
         if (phy == PHY_ADDR) exp_mem[rg] = d;
         chk(r[27] == 1'b0, "R2 valid clear after write", r[27], 0);
      end
      bus_rd(8'h7C, r);
      chk(r == 32'h10, "R8 cause set on completion", r, 32'h10);
      bus_wr(8'h7C, 32'hFFFF_FFEF);
      bus_rd(8'h7C, r);
      chk(r == 32'h0, "R9 cause cleared by zero write", r, 0);
   endtask

   // ---------------- main ----------------
   initial begin
      logic [31:0] r;
      void'($urandom(32'd7));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_rd(8'h00, r); chk(r == 0, "R1 command reset", r, 0);
      bus_rd(8'h7C, r); chk(r == 0, "R1 cause reset", r, 0);
      bus_rd(8'h80, r); chk(r == 0, "R1 mask reset", r, 0);
      chk({mdc, mdio_oe, irq} == 3'b000, "R1 pins idle", {mdc, mdio_oe, irq}, 0);

      // directed: write then read back, present PHY
      run_cmd(1'b0, PHY_ADDR, 5'd9, 16'hBEEF, 1'b0);
      run_cmd(1'b1, PHY_ADDR, 5'd9, 16'h0000, 1'b0);
      // R6 absent PHY
      run_cmd(1'b1, 5'd17, 5'd2, 16'h0000, 1'b0);
      // R7 command while busy
      run_cmd(1'b0, PHY_ADDR, 5'd1, 16'h8001, 1'b1);
      run_cmd(1'b1, PHY_ADDR, 5'd1, 16'h0000, 1'b1);

      // R8/R9 mask and cause interplay
      bus_wr(8'h80, 32'h10);
      bus_rd(8'h80, r); chk(r == 32'h10, "R8 mask readback", r, 32'h10);
      chk(irq == 1'b0, "R8 irq low with cause clear", irq, 0);
      bus_wr(8'h00, {5'b0, 1'b0, 5'd4, PHY_ADDR, 16'h1234});
      exp_mem[4] = 16'h1234;
      repeat (BOUND) @(negedge clk);
      chk(irq == 1'b1, "R8 irq with cause and mask", irq, 1);
      bus_wr(8'h7C, 32'hFFFF_FFFF);
      bus_rd(8'h7C, r); chk(r == 32'h10, "R9 writing one keeps cause", r, 32'h10);
      bus_wr(8'h80, 32'h0);
      #1 chk(irq == 1'b0, "R8 irq masked", irq, 0);
      bus_wr(8'h7C, 32'h0);
      bus_rd(8'h7C, r); chk(r == 32'h0, "R9 cause cleared", r, 0);

      // constrained random
      for (int k = 0; k < 16; k++) begin
         bit rd;
         logic [4:0] phy, rg;
         rd  = 1'($urandom % 2);
         phy = ($urandom % 4 == 0) ? 5'($urandom) | 5'd16 : PHY_ADDR;
         rg  = 5'($urandom);
         run_cmd(rd, phy, rg, 16'($urandom), 1'($urandom % 5 == 0));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog R10 actual=hung expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule